// File: doc/BRIEF.md
# NaN Classifier and Quieting Unit

A purely combinational unit that looks at one floating-point operand in either binary32 or binary64 form and tells whether it is a quiet NaN, a signalling NaN, or neither. In the same pass it produces the quieted form of the operand and the default NaN pattern for the chosen precision. A floating-point datapath uses it at the point where an operation has to forward a NaN operand, or has to raise the invalid flag on a signalling one.

The precision comes from an input. The choice of binary32 or binary64 may change on every cycle. Two elaboration parameters fix the behaviour of one instance:

- `QUIET_INV` sets the meaning of the most significant fraction bit. With the conventional meaning, a 1 in that bit marks a quiet NaN. With the inverted meaning, a 1 in that bit marks a signalling NaN.
- `DNAN_SEL` chooses the default NaN pattern out of three.

Under the inverted meaning, quieting does not set a bit. It replaces the signalling operand with a fixed default pattern.

Top module: `nanq_unit`

## Requirements
- R1: With `QUIET_INV`=0 and `dbl_i`=0, operand bits [30:23] all ones and bit 22 set give `is_qnan_o`=1. Bits [30:23] all ones, bit 22 clear and bits [21:0] nonzero give `is_snan_o`=1.
- R2: With `QUIET_INV`=0 and `dbl_i`=1, the same rule applies using exponent bits [62:52], quiet bit 51 and low fraction bits [50:0].
- R3: An all-ones exponent with an all-zero fraction (infinity) gives `is_qnan_o`=0 and `is_snan_o`=0. Any value whose exponent is not all ones also gives both outputs 0.
- R4: With `QUIET_INV`=1, the roles swap. An all-ones exponent with the top fraction bit set is signalling, even when the rest of the fraction is zero. An all-ones exponent with the top fraction bit clear and a nonzero rest is quiet.
- R5: With `QUIET_INV`=0, a signalling NaN appears on `quiet_o` with the top fraction bit (22 or 51) set and every other bit unchanged.
- R6: With `QUIET_INV`=1, a signalling NaN appears on `quiet_o` as 0x7FBFFFFF in binary32 mode and as 0x7FF7FFFFFFFFFFFF in binary64 mode.
- R7: An operand that is not a signalling NaN appears on `quiet_o` unchanged.
- R8: With `QUIET_INV`=0, `dnan_o` depends on `DNAN_SEL` as follows:
  - 0 gives 0x7FFFFFFF or 0x7FFFFFFFFFFFFFFF.
  - 1 gives 0x7FC00000 or 0x7FF8000000000000.
  - 2 gives 0xFFC00000 or 0xFFF8000000000000.
  With `QUIET_INV`=1, `dnan_o` is the R6 pattern.
- R9: With `dbl_i`=0, `opnd_i[63:32]` has no effect, and `quiet_o[63:32]` and `dnan_o[63:32]` are zero.
- R10: `is_qnan_o` and `is_snan_o` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dbl_i | input | 1 | 1 selects binary64, 0 selects binary32 in bits [31:0] |
| opnd_i | input | 64 | Operand |
| is_qnan_o | output | 1 | Operand is a quiet NaN |
| is_snan_o | output | 1 | Operand is a signalling NaN |
| quiet_o | output | 64 | Operand with a signalling NaN quieted |
| dnan_o | output | 64 | Default NaN for the selected precision |

## Verification
Within one evaluation, the classification of an operand and the quieting substitution on that same operand must agree. A signalling verdict must coincide with a changed `quiet_o`, and any other verdict must leave `quiet_o` equal to the input.

The bench provokes this agreement in two ways:
- It drives operands clustered on the all-ones exponent, with the top fraction bit and the low fraction bits set and cleared independently.
- It switches `dbl_i` between consecutive operands, so that the binary32 and binary64 decodes of the same 64-bit word follow each other.

Each outcome is judged against a bench model of both polarities, evaluated for instances built with either quiet-bit meaning.

// File: rtl/nanq_pkg.sv
package nanq_pkg;
  localparam int SP_EXP_W  = 8;
  localparam int SP_FRAC_W = 23;
  localparam int DP_EXP_W  = 11;
  localparam int DP_FRAC_W = 52;
  localparam int SP_W      = 1 + SP_EXP_W + SP_FRAC_W;
  localparam int DP_W      = 1 + DP_EXP_W + DP_FRAC_W;

  // default NaN choices
  localparam int DNAN_ALL_ONES  = 0;
  localparam int DNAN_POS_QUIET = 1;
  localparam int DNAN_NEG_QUIET = 2;

  typedef struct packed {
    logic qnan;
    logic snan;
  } nan_class_t;
endpackage

// File: rtl/nanq_classify.sv
module nanq_classify
  import nanq_pkg::*;
#(
  parameter int EXP_W     = 8,
  parameter int FRAC_W    = 23,
  parameter bit QUIET_INV = 1'b0,
  localparam int W        = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] val_i,
  output nan_class_t   cls_o
);
  logic exp_ones, top_bit, low_nz;

  always_comb begin
    exp_ones = &val_i[W-2:FRAC_W];
    top_bit  = val_i[FRAC_W-1];
    low_nz   = |val_i[FRAC_W-2:0];
  end

  generate
    if (QUIET_INV) begin : g_inv
      assign cls_o.snan = exp_ones & top_bit;
      assign cls_o.qnan = exp_ones & ~top_bit & low_nz;
    end else begin : g_conv
      assign cls_o.qnan = exp_ones & top_bit;
      assign cls_o.snan = exp_ones & ~top_bit & low_nz;
    end
  endgenerate

  // R3: infinity is never classified as NaN
  always_comb begin
    if (exp_ones && !top_bit && !low_nz)
      a_r3_inf_not_nan: assert (!cls_o.qnan && !cls_o.snan)
        else $error("infinity classified as NaN");
  end
endmodule

// File: rtl/nanq_dnan_gen.sv
module nanq_dnan_gen
  import nanq_pkg::*;
#(
  parameter int EXP_W     = 8,
  parameter int FRAC_W    = 23,
  parameter bit QUIET_INV = 1'b0,
  parameter int DNAN_SEL  = DNAN_POS_QUIET,
  localparam int W        = 1 + EXP_W + FRAC_W
) (
  output logic [W-1:0] dnan_o
);
  localparam logic [EXP_W-1:0]  EXP_ONES = '1;
  localparam logic [FRAC_W-2:0] LOW_ONES = '1;

  generate
    if (QUIET_INV) begin : g_inv
      assign dnan_o = {1'b0, EXP_ONES, 1'b0, LOW_ONES};
    end else if (DNAN_SEL == DNAN_ALL_ONES) begin : g_ones
      assign dnan_o = {1'b0, EXP_ONES, 1'b1, LOW_ONES};
    end else if (DNAN_SEL == DNAN_NEG_QUIET) begin : g_neg
      assign dnan_o = {1'b1, EXP_ONES, 1'b1, {(FRAC_W-1){1'b0}}};
    end else begin : g_pos
      assign dnan_o = {1'b0, EXP_ONES, 1'b1, {(FRAC_W-1){1'b0}}};
    end
  endgenerate
endmodule

// File: rtl/nanq_quieten.sv
module nanq_quieten
  import nanq_pkg::*;
#(
  parameter int EXP_W     = 8,
  parameter int FRAC_W    = 23,
  parameter bit QUIET_INV = 1'b0,
  localparam int W        = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] val_i,
  input  logic         is_snan_i,
  input  logic [W-1:0] dnan_i,
  output logic [W-1:0] quiet_o
);
  localparam logic [W-1:0] QBIT = W'(1) << (FRAC_W - 1);

  generate
    if (QUIET_INV) begin : g_inv
      assign quiet_o = is_snan_i ? dnan_i : val_i;
    end else begin : g_conv
      assign quiet_o = is_snan_i ? (val_i | QBIT) : val_i;
    end
  endgenerate

  always_comb begin
    if (QUIET_INV && is_snan_i)
      a_r6_inv_default: assert (quiet_o == dnan_i)
        else $error("inverted quieting not default");
    if (!QUIET_INV && is_snan_i)
      a_r5_conv_bit_set: assert (quiet_o[FRAC_W-1] && ((quiet_o ^ val_i) == QBIT))
        else $error("conventional quieting wrong");
  end
endmodule

// File: rtl/nanq_lane.sv
module nanq_lane
  import nanq_pkg::*;
#(
  parameter int EXP_W     = 8,
  parameter int FRAC_W    = 23,
  parameter bit QUIET_INV = 1'b0,
  parameter int DNAN_SEL  = DNAN_POS_QUIET,
  localparam int W        = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] val_i,
  output nan_class_t   cls_o,
  output logic [W-1:0] quiet_o,
  output logic [W-1:0] dnan_o
);
  nanq_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .QUIET_INV(QUIET_INV)) u_cls (
    .val_i (val_i),
    .cls_o (cls_o)
  );

  nanq_dnan_gen #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .QUIET_INV(QUIET_INV),
                  .DNAN_SEL(DNAN_SEL)) u_dnan (
    .dnan_o (dnan_o)
  );

  nanq_quieten #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .QUIET_INV(QUIET_INV)) u_qt (
    .val_i     (val_i),
    .is_snan_i (cls_o.snan),
    .dnan_i    (dnan_o),
    .quiet_o   (quiet_o)
  );
endmodule

// File: rtl/nanq_unit.sv
module nanq_unit
  import nanq_pkg::*;
#(
  parameter bit QUIET_INV = 1'b0,
  parameter int DNAN_SEL  = DNAN_POS_QUIET
) (
  input  logic            dbl_i,
  input  logic [DP_W-1:0] opnd_i,
  output logic            is_qnan_o,
  output logic            is_snan_o,
  output logic [DP_W-1:0] quiet_o,
  output logic [DP_W-1:0] dnan_o
);
  localparam int PAD_W = DP_W - SP_W;

  nan_class_t      sp_cls, dp_cls;
  logic [SP_W-1:0] sp_quiet, sp_dnan;
  logic [DP_W-1:0] dp_quiet, dp_dnan;

  nanq_lane #(.EXP_W(SP_EXP_W), .FRAC_W(SP_FRAC_W), .QUIET_INV(QUIET_INV),
              .DNAN_SEL(DNAN_SEL)) u_sp (
    .val_i   (opnd_i[SP_W-1:0]),
    .cls_o   (sp_cls),
    .quiet_o (sp_quiet),
    .dnan_o  (sp_dnan)
  );

  nanq_lane #(.EXP_W(DP_EXP_W), .FRAC_W(DP_FRAC_W), .QUIET_INV(QUIET_INV),
              .DNAN_SEL(DNAN_SEL)) u_dp (
    .val_i   (opnd_i),
    .cls_o   (dp_cls),
    .quiet_o (dp_quiet),
    .dnan_o  (dp_dnan)
  );

  always_comb begin
    if (dbl_i) begin
      is_qnan_o = dp_cls.qnan;
      is_snan_o = dp_cls.snan;
      quiet_o   = dp_quiet;
      dnan_o    = dp_dnan;
    end else begin
      is_qnan_o = sp_cls.qnan;
      is_snan_o = sp_cls.snan;
      quiet_o   = {{PAD_W{1'b0}}, sp_quiet};
      dnan_o    = {{PAD_W{1'b0}}, sp_dnan};
    end
  end

  always_comb begin
    a_r10_exclusive: assert (!(is_qnan_o && is_snan_o))
      else $error("quiet and signalling together");
    if (!dbl_i)
      a_r9_upper_zero: assert (quiet_o[DP_W-1:SP_W] == '0 && dnan_o[DP_W-1:SP_W] == '0)
        else $error("upper half not zero in single mode");
    if (!is_snan_o)
      a_r7_passthru: assert (quiet_o == (dbl_i ? opnd_i : {{PAD_W{1'b0}}, opnd_i[SP_W-1:0]}))
        else $error("non-signalling operand altered");
  end
endmodule

// File: tb/tb_nanq_unit.sv
`timescale 1ns/1ps
module tb_nanq_unit;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic        dbl;
  logic [63:0] opnd;
  logic        q0, s0, q1, s1, qa, sa, qb, sb;
  logic [63:0] qo0, dn0, qo1, dn1, qoa, dna, qob, dnb;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  nanq_unit #(.QUIET_INV(1'b0), .DNAN_SEL(1)) dut (
    .dbl_i(dbl), .opnd_i(opnd), .is_qnan_o(q0), .is_snan_o(s0), .quiet_o(qo0), .dnan_o(dn0));
  nanq_unit #(.QUIET_INV(1'b1), .DNAN_SEL(0)) dut_inv (
    .dbl_i(dbl), .opnd_i(opnd), .is_qnan_o(q1), .is_snan_o(s1), .quiet_o(qo1), .dnan_o(dn1));
  nanq_unit #(.QUIET_INV(1'b0), .DNAN_SEL(0)) dut_s0 (
    .dbl_i(dbl), .opnd_i(opnd), .is_qnan_o(qa), .is_snan_o(sa), .quiet_o(qoa), .dnan_o(dna));
  nanq_unit #(.QUIET_INV(1'b0), .DNAN_SEL(2)) dut_s2 (
    .dbl_i(dbl), .opnd_i(opnd), .is_qnan_o(qb), .is_snan_o(sb), .quiet_o(qob), .dnan_o(dnb));

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic void model(input logic [63:0] op, input bit d, input bit inv,
                                output bit q, output bit s, output bit inf,
                                output logic [63:0] qo);
    logic [63:0] v;
    bit ex1, top, lnz;
    if (d) begin
      ex1 = (op[62:52] == 11'h7FF); top = op[51]; lnz = |op[50:0]; v = op;
    end else begin
      ex1 = (op[30:23] == 8'hFF); top = op[22]; lnz = |op[21:0]; v = {32'h0, op[31:0]};
    end
    inf = ex1 && !top && !lnz;
    if (!inv) begin q = ex1 && top; s = ex1 && !top && lnz; end
    else      begin s = ex1 && top; q = ex1 && !top && lnz; end
    if (s && inv)  qo = d ? 64'h7FF7FFFFFFFFFFFF : 64'h000000007FBFFFFF;
    else if (s)    qo = v | (d ? (64'h1 << 51) : (64'h1 << 22));
    else           qo = v;
  endfunction

  task automatic run_one(input logic [63:0] op, input bit d);
    bit q, s, inf;
    logic [63:0] qo;
    @(posedge clk);
    opnd = op; dbl = d;
    @(negedge clk);
    for (int k = 0; k < 2; k++) begin
      bit inv = (k == 1);
      logic aq = inv ? q1 : q0;
      logic as = inv ? s1 : s0;
      logic [63:0] aqo = inv ? qo1 : qo0;
      string ct, qt;
      model(op, d, inv, q, s, inf, qo);
      ct = inf ? "R3" : (inv ? "R4" : (d ? "R2" : "R1"));
      qt = s ? (inv ? "R6" : "R5") : "R7";
      chk(ct, "qnan", {63'h0, aq}, {63'h0, q});
      chk(ct, "snan", {63'h0, as}, {63'h0, s});
      chk(qt, "quiet", aqo, qo);
      chk("R10", "excl", {63'h0, aq & as}, 64'h0);
      if (!d) chk("R9", "upper", {aqo[63:32], 32'h0}, 64'h0);
    end
    chk("R8", "dnan sel1", dn0, d ? 64'h7FF8000000000000 : 64'h7FC00000);
    chk("R8", "dnan inv",  dn1, d ? 64'h7FF7FFFFFFFFFFFF : 64'h7FBFFFFF);
    chk("R8", "dnan sel0", dna, d ? 64'h7FFFFFFFFFFFFFFF : 64'h7FFFFFFF);
    chk("R8", "dnan sel2", dnb, d ? 64'hFFF8000000000000 : 64'hFFC00000);
  endtask

  function automatic logic [63:0] rand_op(input bit d);
    logic [63:0] r = {$urandom, $urandom};
    int kind = $urandom_range(0, 5);
    if (kind < 5) begin
      if (d) r[62:52] = '1; else r[30:23] = '1;
      if (kind == 1) begin if (d) r[50:0] = '0; else r[21:0] = '0; end
      if (kind == 2) begin if (d) r[51] = 1'b0; else r[22] = 1'b0; end
      if (kind == 3) begin if (d) r[51] = 1'b1; else r[22] = 1'b1; end
    end
    return r;
  endfunction

  initial begin
    #(4ns * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    dbl = 1'b0; opnd = '0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R3", "reset qnan", {63'h0, q0}, 64'h0);
    chk("R7", "reset quiet", qo0, 64'h0);
    // directed corners
    run_one(64'h0000_0000_7FC0_0000, 0);
    run_one(64'h0000_0000_7F80_0001, 0);
    run_one(64'h0000_0000_7F80_0000, 0);   // R3 infinity
    run_one(64'h0000_0000_FFA0_0000, 0);
    run_one(64'hFFFF_FFFF_7F80_0001, 0);   // R9 junk upper
    run_one(64'h0000_0000_3F80_0000, 0);
    run_one(64'h7FF8_0000_0000_0000, 1);
    run_one(64'h7FF0_0000_0000_0001, 1);
    run_one(64'hFFF0_0000_0000_0000, 1);   // R3 infinity
    run_one(64'h7FF8_0000_0000_0000, 0);   // R9 same word, single
    run_one(64'h7FF4_0000_0000_0000, 1);
    for (int i = 0; i < 3000; i++) begin
      bit d = $urandom_range(0, 1);
      run_one(rand_op(d), d);
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule